// File: doc/BRIEF.md
# Reset and Power-On Sequencing Controller

This block decides, on a slow free-running reference clock, whether the device is powered and whether its logic is held in reset. It watches three inputs: an asynchronous active-low reset pin, a power button and a charger-present level. It drives a regulator enable, an active-low internal reset and a two-bit power state. Each input passes through a synchroniser before use. The reset pin also passes a stability filter, so short spurious low pulses are dropped. Every accepted reset is stretched to a guaranteed minimum length.

A reset held on the pin keeps the rails up, and the logic restarts when the pin is released. A hold longer than the protection timeout powers the device down, but only while the charger is absent and the button is released. Once off, the device comes back up when a charger is attached, or when the button is held continuously for the power-on time. All time constants are parameters counted in reference-clock cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and afterwards until a wake condition occurs, the state output is OFF (code 00), `reg_en` is 0 and `sys_rst_n` is 0.
- R2: The state codes are 00 OFF, 01 POWERING_UP, 10 ON and 11 IN_RESET. `reg_en` is 1 in every state except OFF. `sys_rst_n` is 1 only in ON. All three outputs are registered and change together.
- R3: A low pulse on `rst_pin_n` that lasts fewer than FILT_CYCLES reference cycles causes no reset: the state stays ON and `sys_rst_n` stays 1.
- R4: A low level on `rst_pin_n` that lasts FILT_CYCLES reference cycles or longer is always accepted and moves the block into IN_RESET.
- R5: Each stay in IN_RESET lasts at least EXT_CYCLES cycles. When the pin is released earlier, it lasts exactly EXT_CYCLES cycles.
- R6: If the reset pin is released before the filtered low has lasted HOLD_OFF_CYCLES, the block returns to ON, and `reg_en` stays 1 throughout.
- R7: Once the filtered reset has been held for HOLD_OFF_CYCLES with the charger absent and the button low, the block enters OFF with `reg_en` at 0. It stays OFF after the pin is released.
- R8: While the charger-present input is high, the block never enters OFF, however long reset is held.
- R9: A button held high when the hold timeout is reached keeps the block in IN_RESET. The block enters OFF as soon as the button goes low while reset is still held.
- R10: From OFF, the button must be held high for BTN_ON_CYCLES consecutive cycles to start power-up. Shorter presses, including BTN_ON_CYCLES-1 cycles, are ignored.
- R11: From OFF, a high charger-present input starts power-up.
- R12: POWERING_UP lasts exactly PWRUP_CYCLES cycles and then becomes ON, unless a reset is accepted first.
- R13: The hold counters saturate instead of wrapping, and they clear whenever their input goes low. An interrupted button press restarts the count, and a saturated reset hold still triggers power-down when the charger is later removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high reset of this logic |
| rst_pin_n | input | 1 | Asynchronous active-low reset request from the pin |
| pwr_btn | input | 1 | Power button, high when pressed |
| chg_present | input | 1 | Charger attached, high when present |
| state_o | output | 2 | Power state code |
| reg_en | output | 1 | Regulator enable, active high |
| sys_rst_n | output | 1 | Internal reset, active low |

## Verification
The hardest condition to reach from the ports is a reset hold timer that has saturated while power-down is blocked. The case must then show that the saturated count still acts when the blocking input goes away. The stimulus holds the pin low well past the timeout, and past the counter's binary wrap point, with the charger attached. It then removes the charger while the pin is still low. It repeats the same sequence with the button as the blocking input. Button presses one cycle short of the power-on time, and presses broken by a brief release, exercise the edges of the button timer. A behavioural model in the bench tracks every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'b00,
        PS_PWRUP = 2'b01,
        PS_ON    = 2'b10,
        PS_INRST = 2'b11
    } pwr_state_e;

    // synchronised pin levels, bit order matches the synchroniser vector
    typedef struct packed {
        logic rst_pin_n;
        logic btn;
        logic chg;
    } pin_sync_t;

    // decoded conditions seen by the state machine
    typedef struct packed {
        logic rst_act;    // filtered reset request
        logic hold_done;  // reset held beyond protection timeout
        logic btn_done;   // button held for power-on time
        logic btn;        // synchronised button level
        logic chg;        // synchronised charger level
    } seq_cond_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        if (max_val < 2)
            return 1;
        return $clog2(max_val + 1);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES < 2) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q <= RST_VAL;
                else
                    stage_q <= d_i;
            end
            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst)
                    chain_q <= {STAGES{RST_VAL}};
                else
                    chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pwr_deglitch.sv
module pwr_deglitch #(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    import pwr_seq_pkg::*;

    localparam int unsigned CW = cnt_width(STABLE_CYCLES - 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] diff_cnt;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= 1'b0;
            diff_cnt <= '0;
        end else if (raw_i == level_q) begin
            diff_cnt <= '0;
        end else if (diff_cnt == LAST) begin
            level_q  <= raw_i;
            diff_cnt <= '0;
        end else begin
            diff_cnt <= diff_cnt + CW'(1);
        end
    end

    assign clean_o = level_q;

    // a change of the clean level must follow a raw sample of that level
    assert_filter_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(raw_i) == level_q));

    // a raw level that agrees with the clean level never flips it
    assert_filter_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (raw_i == level_q) |=> (level_q == $past(level_q)));

endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic done_o
);
    import pwr_seq_pkg::*;

    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= '0;
        else if (!level_i)
            hold_cnt <= '0;
        else if (hold_cnt != TOP)
            hold_cnt <= hold_cnt + CW'(1);
    end

    assign done_o = (hold_cnt == TOP);

    assert_hold_clears_R13: assert property (@(posedge clk) disable iff (rst)
        !level_i |=> (hold_cnt == '0));

    assert_hold_saturates_R13: assert property (@(posedge clk) disable iff (rst)
        (done_o && level_i) |=> done_o);

    assert_hold_bounded_R13: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= TOP);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 32,
    parameter int unsigned EXT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_cond_t  cond_i,
    output pwr_state_e state_o,
    output logic       reg_en_o,
    output logic       sys_rst_n_o
);

    localparam int unsigned DW_MAX = max_of(PWRUP_CYCLES, EXT_CYCLES);
    localparam int unsigned DW = cnt_width(DW_MAX);
    localparam logic [DW-1:0] DWELL_TOP = DW'(DW_MAX);
    localparam logic [DW-1:0] PWRUP_LAST = DW'(PWRUP_CYCLES - 1);
    localparam logic [DW-1:0] EXT_LAST = DW'(EXT_CYCLES - 1);

    pwr_state_e state_q, state_d;
    logic [DW-1:0] dwell_q;
    logic reg_en_q, sys_rst_n_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PS_OFF: begin
                if (cond_i.chg || cond_i.btn_done)
                    state_d = PS_PWRUP;
            end
            PS_PWRUP: begin
                if (cond_i.rst_act)
                    state_d = PS_INRST;
                else if (dwell_q >= PWRUP_LAST)
                    state_d = PS_ON;
            end
            PS_ON: begin
                if (cond_i.rst_act)
                    state_d = PS_INRST;
            end
            PS_INRST: begin
                if (cond_i.hold_done && !cond_i.chg && !cond_i.btn)
                    state_d = PS_OFF;
                else if (!cond_i.rst_act && dwell_q >= EXT_LAST)
                    state_d = PS_ON;
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PS_OFF;
            dwell_q     <= '0;
            reg_en_q    <= 1'b0;
            sys_rst_n_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            reg_en_q    <= (state_d != PS_OFF);
            sys_rst_n_q <= (state_d == PS_ON);
            if (state_d != state_q)
                dwell_q <= '0;
            else if (dwell_q != DWELL_TOP)
                dwell_q <= dwell_q + DW'(1);
        end
    end

    assign state_o     = state_q;
    assign reg_en_o    = reg_en_q;
    assign sys_rst_n_o = sys_rst_n_q;

    assert_no_off_with_charger_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_i.chg && state_q != PS_OFF) |=> (state_q != PS_OFF));

    assert_off_needs_wake_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_OFF && !cond_i.chg && !cond_i.btn_done) |=> (state_q == PS_OFF));

    assert_off_only_from_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_PWRUP || state_q == PS_ON) |=> (state_q != PS_OFF));

    assert_reset_stretched_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_INRST && dwell_q < EXT_LAST) |=> (state_q != PS_ON));

    assert_pwrup_length_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_PWRUP && dwell_q < PWRUP_LAST) |=> (state_q != PS_ON));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYCLES = 4,
    parameter int unsigned EXT_CYCLES = 16,
    parameter int unsigned PWRUP_CYCLES = 32,
    parameter int unsigned HOLD_OFF_CYCLES = 58982,
    parameter int unsigned BTN_ON_CYCLES = 656
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin_n,
    input  logic       pwr_btn,
    input  logic       chg_present,
    output logic [1:0] state_o,
    output logic       reg_en,
    output logic       sys_rst_n
);
    import pwr_seq_pkg::*;

    localparam int unsigned PIN_W = $bits(pin_sync_t);
    localparam pin_sync_t PIN_IDLE = '{rst_pin_n: 1'b1, btn: 1'b0, chg: 1'b0};

    pin_sync_t  pins_raw, pins_sync;
    seq_cond_t  cond;
    pwr_state_e state;
    logic       rst_req_sync;

    assign pins_raw = '{rst_pin_n: rst_pin_n, btn: pwr_btn, chg: chg_present};

    pwr_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (PIN_W),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(pins_raw),
        .q_o(pins_sync)
    );

    assign rst_req_sync = ~pins_sync.rst_pin_n;

    pwr_deglitch #(
        .STABLE_CYCLES(FILT_CYCLES)
    ) u_deglitch (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (rst_req_sync),
        .clean_o(cond.rst_act)
    );

    pwr_hold_timer #(
        .LIMIT(HOLD_OFF_CYCLES)
    ) u_rst_hold (
        .clk    (clk),
        .rst    (rst),
        .level_i(cond.rst_act),
        .done_o (cond.hold_done)
    );

    pwr_hold_timer #(
        .LIMIT(BTN_ON_CYCLES)
    ) u_btn_hold (
        .clk    (clk),
        .rst    (rst),
        .level_i(pins_sync.btn),
        .done_o (cond.btn_done)
    );

    assign cond.btn = pins_sync.btn;
    assign cond.chg = pins_sync.chg;

    pwr_fsm #(
        .PWRUP_CYCLES(PWRUP_CYCLES),
        .EXT_CYCLES  (EXT_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond),
        .state_o    (state),
        .reg_en_o   (reg_en),
        .sys_rst_n_o(sys_rst_n)
    );

    assign state_o = state;

    assert_rails_follow_state_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_en == (state_o != 2'b00)) && (sys_rst_n == (state_o == 2'b10)));

endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;

    localparam int FILT = 4;
    localparam int EXT = 8;
    localparam int PWRUP = 6;
    localparam int HOLD = 200;
    localparam int BTN = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin_n = 1'b1;
    logic pwr_btn = 1'b0;
    logic chg_present = 1'b0;
    logic [1:0] state_o;
    logic reg_en, sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(
        .SYNC_STAGES(2),
        .FILT_CYCLES(FILT),
        .EXT_CYCLES(EXT),
        .PWRUP_CYCLES(PWRUP),
        .HOLD_OFF_CYCLES(HOLD),
        .BTN_ON_CYCLES(BTN)
    ) u_pwr_seq_ctrl (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .pwr_btn(pwr_btn),
        .chg_present(chg_present), .state_o(state_o), .reg_en(reg_en),
        .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference: pin history, timers as plain integers
    int p1, p2, b1, b2, c1, c2;
    int m_flt, m_fdiff, m_hold, m_bhold, m_state, m_time;

    always @(posedge clk) begin
        if (rst) begin
            p1 = 1; p2 = 1; b1 = 0; b2 = 0; c1 = 0; c2 = 0;
            m_flt = 0; m_fdiff = 0; m_hold = 0; m_bhold = 0;
            m_state = 0; m_time = 0;
        end else begin
            int nxt;
            nxt = m_state;
            if (m_state == 0 && (c2 == 1 || m_bhold >= BTN)) nxt = 1;
            else if ((m_state == 1 || m_state == 2) && m_flt == 1) nxt = 3;
            else if (m_state == 1 && m_time >= PWRUP - 1) nxt = 2;
            else if (m_state == 3 && m_hold >= HOLD && c2 == 0 && b2 == 0) nxt = 0;
            else if (m_state == 3 && m_flt == 0 && m_time >= EXT - 1) nxt = 2;
            m_time = (nxt != m_state) ? 0 : m_time + 1;
            m_state = nxt;
            m_hold = (m_flt == 1) ? m_hold + 1 : 0;
            m_bhold = (b2 == 1) ? m_bhold + 1 : 0;
            if ((p2 == 0) != (m_flt == 1)) begin
                m_fdiff = m_fdiff + 1;
                if (m_fdiff >= FILT) begin
                    m_flt = (p2 == 0) ? 1 : 0;
                    m_fdiff = 0;
                end
            end else begin
                m_fdiff = 0;
            end
            p2 = p1; p1 = rst_pin_n;
            b2 = b1; b1 = pwr_btn;
            c2 = c1; c1 = chg_present;
        end
    end

    // per-cycle comparison and run-length bookkeeping
    logic [1:0] prev_state = 2'b00;
    int run_len = 0;
    int last_pwrup = 0;
    int last_inrst = 0;
    bit saw_rst_low = 1'b0;
    bit saw_en_low = 1'b0;

    always @(negedge clk) begin
        if (armed) begin
            chk(state_o == m_state[1:0], "R2 state vs model", state_o, m_state);
            chk(reg_en == (state_o != 2'b00), "R2 reg_en decode", reg_en, state_o != 2'b00);
            chk(sys_rst_n == (state_o == 2'b10), "R2 sys_rst_n decode", sys_rst_n, state_o == 2'b10);
            if (state_o == prev_state) begin
                run_len++;
            end else begin
                if (prev_state == 2'b01) last_pwrup = run_len;
                if (prev_state == 2'b11) last_inrst = run_len;
                run_len = 1;
            end
            prev_state = state_o;
            if (!sys_rst_n) saw_rst_low = 1'b1;
            if (!reg_en) saw_en_low = 1'b1;
        end
    end

    task automatic pin_low(input int n);
        rst_pin_n = 1'b0;
        cyc(n);
        rst_pin_n = 1'b1;
    endtask

    task automatic press(input int n);
        pwr_btn = 1'b1;
        cyc(n);
        pwr_btn = 1'b0;
    endtask

    initial begin
        cyc(5);
        armed = 1'b1;
        chk(state_o == 2'b00, "R1 state in reset", state_o, 0);
        chk(reg_en == 1'b0, "R1 reg_en in reset", reg_en, 0);
        chk(sys_rst_n == 1'b0, "R1 sys_rst_n in reset", sys_rst_n, 0);
        rst = 1'b0;
        cyc(10);
        chk(state_o == 2'b00, "R1 idle after reset", state_o, 0);

        press(30);
        cyc(60);
        chk(state_o == 2'b00, "R10 short press ignored", state_o, 0);

        pwr_btn = 1'b1; cyc(40); pwr_btn = 1'b0; cyc(2); press(40);
        cyc(60);
        chk(state_o == 2'b00, "R13 broken press restarts count", state_o, 0);

        press(BTN - 1);
        cyc(60);
        chk(state_o == 2'b00, "R10 press one short ignored", state_o, 0);

        press(BTN);
        cyc(30);
        chk(state_o == 2'b10, "R10 full press powers up", state_o, 2);
        chk(last_pwrup == PWRUP, "R12 power-up length", last_pwrup, PWRUP);

        saw_rst_low = 1'b0;
        pin_low(FILT - 1);
        cyc(20);
        chk(state_o == 2'b10, "R3 glitch keeps ON", state_o, 2);
        chk(saw_rst_low == 1'b0, "R3 glitch no internal reset", saw_rst_low, 0);

        saw_rst_low = 1'b0;
        pin_low(FILT);
        cyc(30);
        chk(saw_rst_low == 1'b1, "R4 minimum pulse accepted", saw_rst_low, 1);
        chk(last_inrst == EXT, "R5 stretched reset length", last_inrst, EXT);
        chk(state_o == 2'b10, "R5 back to ON", state_o, 2);

        saw_en_low = 1'b0;
        rst_pin_n = 1'b0;
        cyc(100);
        chk(state_o == 2'b11, "R6 held reset in IN_RESET", state_o, 3);
        cyc(20);
        rst_pin_n = 1'b1;
        cyc(30);
        chk(state_o == 2'b10, "R6 release restarts", state_o, 2);
        chk(saw_en_low == 1'b0, "R6 rails stayed on", saw_en_low, 0);

        chg_present = 1'b1;
        rst_pin_n = 1'b0;
        cyc(300);
        chk(state_o == 2'b11, "R8 charger blocks OFF", state_o, 3);
        chk(reg_en == 1'b1, "R8 rails on with charger", reg_en, 1);
        chg_present = 1'b0;
        cyc(10);
        chk(state_o == 2'b00, "R13 saturated hold acts after charger drop", state_o, 0);
        rst_pin_n = 1'b1;
        cyc(20);
        chk(state_o == 2'b00, "R7 stays OFF after release", state_o, 0);

        chg_present = 1'b1;
        cyc(30);
        chk(state_o == 2'b10, "R11 charger wakes", state_o, 2);
        chg_present = 1'b0;
        cyc(5);

        pwr_btn = 1'b1;
        rst_pin_n = 1'b0;
        cyc(290);
        chk(state_o == 2'b11, "R9 button blocks OFF", state_o, 3);
        pwr_btn = 1'b0;
        cyc(10);
        chk(state_o == 2'b00, "R9 OFF after button release", state_o, 0);
        rst_pin_n = 1'b1;
        cyc(10);

        press(BTN + 10);
        cyc(30);
        chk(state_o == 2'b10, "R10 button wake again", state_o, 2);

        rst_pin_n = 1'b0;
        cyc(250);
        chk(state_o == 2'b00, "R7 long hold powers down", state_o, 0);
        chk(reg_en == 1'b0, "R7 rails off", reg_en, 0);
        rst_pin_n = 1'b1;
        cyc(20);
        chk(state_o == 2'b00, "R7 OFF after release", state_o, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule